// File: doc/BRIEF.md
# Bit-Synchronous Receiver with Sync-Character Hunt

This block receives a continuous serial bit stream in which every clock edge carries one data bit, with the clock delivered alongside the data. The stream has no start or stop framing. Bytes follow each other back to back, and the only way to find where a byte begins is to look for a known alignment character in the stream.

After reset, or when commanded, the receiver is in hunt mode. In this mode it compares the last eight received bits against a programmable sync character on every bit. A match is reported with a one-cycle pulse, and the receiver then switches to byte mode. In byte mode it takes each following run of eight bits as one byte, with the earliest bit as the least significant. It offers each byte on a data output with a valid flag that stays up until the consumer accepts it. If a new byte completes while the previous one is still waiting, a sticky overrun flag is set. The hunt command discards the current alignment and starts a fresh search.

Top module: `syncRx`

## Requirements
- R1: After reset, huntMode is 1 and syncFound, byteValid and overrun are all 0.
- R2: Bits are taken least significant first. For sync matching and for received bytes, bit 0 of the 8-bit value is the earliest of the eight bits and bit 7 is the latest.
- R3: In hunt mode, no match is possible until eight bits have been shifted in since reset or since the last hunt command. The bit sampled in the same cycle as the hunt command does not count toward those eight.
- R4: When the eight most recent bits equal syncPattern in hunt mode, syncFound is 1 for exactly one cycle, in the cycle after the edge that sampled the last pattern bit. huntMode falls in that same cycle.
- R5: In byte mode, every eight consecutive bits form one byte. byteData takes the new byte and byteValid is 1 in the cycle after the edge that sampled the eighth bit.
- R6: In byte mode, no sync comparison is made. A copy of the sync character inside the data neither pulses syncFound nor moves the byte boundary.
- R7: byteValid stays 1 until an edge where byteAccept is 1. That edge clears it, unless a new byte completes at the same edge.
- R8: If a byte completes at an edge where byteValid is 1 and byteAccept is 0, overrun becomes 1 and stays 1 until the next hunt command. If byteAccept is 1 at that edge, no overrun occurs.
- R9: huntCmd sampled at an edge returns the block to hunt mode, clears the bit count and overrun, and keeps syncFound at 0 in the following cycle. byteData is kept, and byteValid follows R7.
- R10: syncPattern is sampled on every bit in hunt mode, so a new value takes effect on the next bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock supplied with the data, one edge per bit |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Serial data bit sampled on each rising edge |
| syncPattern | input | 8 | Sync character, bit 0 is the first bit on the line |
| huntCmd | input | 1 | Return to hunt mode |
| byteAccept | input | 1 | Consumer takes the presented byte |
| syncFound | output | 1 | One-cycle pulse on sync detection |
| huntMode | output | 1 | 1 while searching for the sync character |
| byteData | output | 8 | Most recently assembled byte |
| byteValid | output | 1 | byteData holds a byte not yet accepted |
| overrun | output | 1 | Sticky: a byte completed before the previous one was accepted |

## Verification
An all-zero sync character is sent over an all-zero line right after reset and after a hunt command. This separates a correct eight-bit fill guard from a comparator that trusts the reset contents of the shift register. An asymmetric sync character sent after noise, followed by data that contains the same character, tests both the bit order and the rule that byte mode ignores further matches. Runs in which bytes are accepted, left waiting, and accepted exactly at completion separate the hold, overrun and same-edge cases. A hunt command in the middle of a byte, followed by a pattern change, tests realignment and the use of a freshly programmed character. A behavioural model compares all outputs on every cycle.

// File: rtl/syncRxPkg.sv
package syncRxPkg;
  typedef enum logic {MODE_HUNT = 1'b0, MODE_BYTE = 1'b1} rxMode_e;

  typedef struct packed {
    logic compareEn;
    logic capture;
  } rxStrobes_t;
endpackage

// File: rtl/syncRxDatapath.sv
module syncRxDatapath
  import syncRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic [DATA_W-1:0] syncPattern,
  input  rxStrobes_t        strb,
  output logic              match,
  output logic [DATA_W-1:0] byteData
);
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] nextShift;

  // newest bit enters at the top, so the oldest of the last DATA_W bits sits at bit 0
  assign nextShift = {bitIn, shiftReg[DATA_W-1:1]};
  assign match     = strb.compareEn && (nextShift == syncPattern);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      byteData <= '0;
    end else begin
      shiftReg <= nextShift;
      if (strb.capture) byteData <= nextShift;
    end
  end

  a_r6_no_compare_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> !match);
endmodule

// File: rtl/syncRxControl.sv
module syncRxControl
  import syncRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       huntCmd,
  input  logic       byteAccept,
  input  logic       match,
  output rxStrobes_t strb,
  output logic       syncFound,
  output logic       huntMode,
  output logic       byteValid,
  output logic       overrun
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  rxMode_e          mode;
  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strb.compareEn = (mode == MODE_HUNT) && (fillCnt == LAST) && !huntCmd;
    strb.capture   = (mode == MODE_BYTE) && (bitCnt == LAST) && !huntCmd;
  end

  assign huntMode = (mode == MODE_HUNT);

  // alignment state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode      <= MODE_HUNT;
      fillCnt   <= '0;
      bitCnt    <= '0;
      syncFound <= 1'b0;
    end else if (huntCmd) begin
      mode      <= MODE_HUNT;
      fillCnt   <= '0;
      bitCnt    <= '0;
      syncFound <= 1'b0;
    end else begin
      syncFound <= 1'b0;
      if (mode == MODE_HUNT) begin
        if (fillCnt != LAST) begin
          fillCnt <= fillCnt + 1'b1;
        end else if (match) begin
          mode      <= MODE_BYTE;
          bitCnt    <= '0;
          syncFound <= 1'b1;
        end
      end else begin
        bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  // output handshake and overrun
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteValid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (strb.capture) begin
        byteValid <= 1'b1;
        if (byteValid && !byteAccept) overrun <= 1'b1;
      end else if (byteAccept) begin
        byteValid <= 1'b0;
      end
      if (huntCmd) overrun <= 1'b0;
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    syncFound |=> !syncFound);
  a_r4_leaves_hunt: assert property (@(posedge clk) disable iff (!rstN)
    syncFound |-> !huntMode);
  a_r7_valid_holds: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !byteAccept) |=> byteValid);
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !huntCmd) |=> overrun);
  a_r9_hunt_restart: assert property (@(posedge clk) disable iff (!rstN)
    huntCmd |=> (huntMode && !overrun && !syncFound));
  a_r3_fill_guard: assert property (@(posedge clk) disable iff (!rstN)
    huntCmd |=> !syncFound ##1 !syncFound);
endmodule

// File: rtl/syncRx.sv
module syncRx
  import syncRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic [DATA_W-1:0] syncPattern,
  input  logic              huntCmd,
  input  logic              byteAccept,
  output logic              syncFound,
  output logic              huntMode,
  output logic [DATA_W-1:0] byteData,
  output logic              byteValid,
  output logic              overrun
);
  rxStrobes_t strb;
  logic       match;

  syncRxDatapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .syncPattern(syncPattern),
    .strb(strb), .match(match), .byteData(byteData)
  );

  syncRxControl #(.DATA_W(DATA_W)) i_control (
    .clk(clk), .rstN(rstN), .huntCmd(huntCmd), .byteAccept(byteAccept),
    .match(match), .strb(strb), .syncFound(syncFound), .huntMode(huntMode),
    .byteValid(byteValid), .overrun(overrun)
  );
endmodule

// File: tb/test_syncRx.sv
module test_syncRx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitIn = 1'b0;
  logic [7:0] syncPattern = 8'h00;
  logic       huntCmd = 1'b0;
  logic       byteAccept = 1'b0;
  logic       syncFound, huntMode, byteValid, overrun;
  logic [7:0] byteData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string phaseReq = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  syncRx i_syncRx (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .syncPattern(syncPattern),
    .huntCmd(huntCmd), .byteAccept(byteAccept), .syncFound(syncFound),
    .huntMode(huntMode), .byteData(byteData), .byteValid(byteValid),
    .overrun(overrun)
  );

  // behavioural reference
  bit mHunt = 1, mSync = 0, mValid = 0, mOvr = 0;
  int mFill = 0, mCnt = 0;
  logic [7:0] mData = 8'h00;
  bit bitQ[$];

  function automatic logic [7:0] lastEight();
    logic [7:0] v = 8'h00;
    for (int i = 0; i < 8; i++) v[i] = bitQ[bitQ.size() - 8 + i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mHunt = 1; mSync = 0; mValid = 0; mOvr = 0; mFill = 0; mCnt = 0; mData = 8'h00;
      bitQ.delete();
    end else begin
      bit done8;
      done8 = 0;
      bitQ.push_back(bitIn);
      if (bitQ.size() > 16) void'(bitQ.pop_front());
      mSync = 0;
      if (huntCmd) begin
        mHunt = 1; mFill = 0; mCnt = 0;
      end else if (mHunt) begin
        mFill++;
        if (mFill >= 8 && lastEight() == syncPattern) begin
          mSync = 1; mHunt = 0; mCnt = 0;
        end
      end else begin
        mCnt++;
        if (mCnt == 8) begin
          mCnt = 0; done8 = 1;
        end
      end
      if (done8) begin
        if (mValid && !byteAccept) mOvr = 1;
        mValid = 1; mData = lastEight();
      end else if (byteAccept) mValid = 0;
      if (huntCmd) mOvr = 0;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) at cycle %0d: actual %h expected %h", req, phaseReq, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      check("R4 syncFound", {7'b0, syncFound}, {7'b0, mSync});
      check("R9 huntMode", {7'b0, huntMode}, {7'b0, mHunt});
      check("R7 byteValid", {7'b0, byteValid}, {7'b0, mValid});
      check("R8 overrun", {7'b0, overrun}, {7'b0, mOvr});
      check("R5 byteData", byteData, mData);
    end
    if (cycles > 100000 && !done) begin
      fails++;
      done = 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic sendBit(bit b, bit acc, bit hunt);
    @(negedge clk);
    bitIn = b; byteAccept = acc; huntCmd = hunt;
  endtask

  task automatic sendByte(logic [7:0] v, bit acc);
    for (int i = 0; i < 8; i++) sendBit(v[i], acc, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phaseReq = "R1";
    check("R1 huntMode", {7'b0, huntMode}, 8'h01);
    check("R1 syncFound", {7'b0, syncFound}, 8'h00);
    check("R1 byteValid", {7'b0, byteValid}, 8'h00);
    check("R1 overrun", {7'b0, overrun}, 8'h00);
    rstN = 1'b1;

    // all-zero sync must wait for a full fill of eight bits
    phaseReq = "R3";
    syncPattern = 8'h00;
    for (int i = 0; i < 10; i++) sendBit(1'b0, 1'b0, 1'b0);
    sendBit(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 10; i++) sendBit(1'b0, 1'b0, 1'b0);

    // asymmetric sync after noise, then data that repeats it
    phaseReq = "R2";
    sendBit(1'b0, 1'b1, 1'b1);
    syncPattern = 8'h1E;
    sendByte(8'hB3, 1'b1);
    sendByte(8'h1E, 1'b1);
    phaseReq = "R6";
    sendByte(8'hA5, 1'b1);
    sendByte(8'h1E, 1'b1);
    sendByte(8'h3C, 1'b1);

    // leave bytes waiting, then accept at completion
    phaseReq = "R8";
    sendByte(8'h81, 1'b0);
    sendByte(8'h42, 1'b0);
    sendByte(8'h99, 1'b0);
    phaseReq = "R7";
    for (int i = 0; i < 7; i++) sendBit(i[0], 1'b0, 1'b0);
    sendBit(1'b1, 1'b1, 1'b0);
    sendByte(8'h5A, 1'b1);

    // hunt mid-byte with a newly programmed pattern
    phaseReq = "R9";
    sendBit(1'b1, 1'b0, 1'b0);
    sendBit(1'b0, 1'b0, 1'b0);
    sendBit(1'b1, 1'b0, 1'b1);
    phaseReq = "R10";
    syncPattern = 8'hC6;
    sendByte(8'h1E, 1'b1);
    sendByte(8'hC6, 1'b1);
    sendByte(8'h77, 1'b1);
    sendByte(8'h0F, 1'b0);
    sendBit(1'b0, 1'b1, 1'b0);
    repeat (3) sendBit(1'b0, 1'b0, 1'b0);

    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule